// File: doc/BRIEF.md
# Multiplexed External Bus Address Sequencer

This block runs single accesses on an 8-bit multiplexed external bus. Each access is one of three kinds: a code read, a data access through an 8-bit register, or a data access through a 16-bit pointer. A code read comes in two forms: a table read whose low 16 bits come from a pointer, and an instruction fetch taken straight from the program counter. The block forms the full address from the sources that match the kind. It then steps through a fixed phase sequence: address latch, hold, strobe and completion. During that sequence it drives the low address/data port, the high address port, the latch enable and one of three active-low strobes.

A mode bit selects between two addressing modes, and it is sampled when a request is accepted. In classic mode the bus carries a 16-bit address and the high port holds address bits 15:8 for the whole access. In extended mode the bus carries a 23-bit address and the high port is shared over time. While the latch enable is high, it carries the top address bits so that an external latch can capture them. After the latch enable falls, it carries bits 15:8, which are not latched and must stay steady through the strobe. Write data leaves on the low port and read data is sampled from it. The external latches and memories are outside the block.

Top module: `xbus_seq`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle. In that state ale=0, psen_n=rd_n=wr_n=1, busy=0, done=0, p0_oe=0 and p2_out=0. Asserting reset in the middle of an access forces these values at once.
- R2: With the sampled mode bit at 0, p2_out equals address bits 15:8 from the latch phase through the completion cycle. p0_out carries address bits 7:0, with p0_oe=1, during the latch phase and the hold phase.
- R3: With the sampled mode bit at 1, p2_out equals address bits 22:16, zero-padded to 8 bits, while ale=1. From the hold phase through strobe release it equals address bits 15:8 and stays stable while the strobe is low. p0_out carries bits 7:0 during the latch and hold phases.
- R4: The address is formed from req_kind as follows. Kind 0 (code table read) gives {pc[22:16], ptr}. Kind 1 (register data) gives bits 22:8 zero and reg_byte as bits 7:0. Kind 2 (pointer data) gives bits 22:16 zero and ptr as bits 15:0. Kind 3 (instruction fetch) gives pc.
- R5: A request is accepted on a rising edge when req_valid=1 and the block is idle. The next cycle has ale=1. The cycle after that is a hold cycle with ale=0 and no strobe. Then the strobe is low for STROBE_CYC cycles (default 2), followed by one completion cycle. busy=1 from the latch cycle through the completion cycle.
- R6: Kinds 0 and 3 pulse psen_n, and req_write is ignored for them. Kinds 1 and 2 pulse rd_n when req_write=0 and wr_n when req_write=1. At most one strobe is low at any time.
- R7: ale and any strobe are never active in the same cycle.
- R8: On a data write, p0_oe=1 and p0_out=wdata during every strobe-low cycle. On any read, p0_oe=0 while the strobe is low.
- R9: On a read, rd_data takes the p0_in value present in the last strobe-low cycle, that is, at the edge where the strobe rises. It shows that value from the completion cycle onward and keeps it through writes until the next read.
- R10: Changes to req_valid, the mode bit, the kind or any address or data input while busy=1 have no effect on the access in progress, and no request is queued from them.
- R11: done=1 for exactly one cycle, the completion cycle, at the end of each access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_mode | input | 1 | 0: classic 16-bit addressing, 1: extended 23-bit addressing |
| req_valid | input | 1 | Access request, accepted only when idle |
| req_kind | input | 2 | 0 code table, 1 register data, 2 pointer data, 3 instruction fetch |
| req_write | input | 1 | Data write when 1 (ignored for code kinds) |
| pc | input | 23 | Program counter |
| reg_byte | input | 8 | Register byte for register-indirect access |
| ptr | input | 16 | 16-bit pointer / code offset |
| wdata | input | 8 | Write data |
| p0_in | input | 8 | Low port input (read data) |
| p0_out | output | 8 | Low port output (address low byte / write data) |
| p0_oe | output | 1 | Low port output enable |
| p2_out | output | 8 | High address port |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last captured read byte |

## Verification
The checker tests a set of pin rules on every cycle. Strobes are mutually exclusive and never overlap the latch enable. The high port does not move while a strobe is held low. The low port is driven during write strobes and released during read strobes. The done pulse lasts a single cycle and falls inside busy. Other behaviours can only be shown by the bench scenarios, which check them phase by phase against separately computed values. These are the address formed for each kind, the mode-dependent byte order on the high port, the exact phase timing, the edge at which read data is sampled, and the fact that inputs changed during a busy access are ignored and not queued.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // access kinds on req_kind
  localparam logic [1:0] KIND_CODE_TBL = 2'd0;
  localparam logic [1:0] KIND_REG8     = 2'd1;
  localparam logic [1:0] KIND_PTR16    = 2'd2;
  localparam logic [1:0] KIND_FETCH    = 2'd3;

  // bus phases of one access
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ALE  = 3'd1,
    PH_HOLD = 3'd2,
    PH_STRB = 3'd3,
    PH_DONE = 3'd4
  } phase_e;

  // attributes captured with a request
  typedef struct packed {
    logic ext;      // extended addressing for this access
    logic is_code;  // code space read
    logic wr;       // data write
  } acc_attr_t;

endpackage

// File: rtl/xbus_addr_form.sv
module xbus_addr_form #(
  parameter int ADDR_W = 23
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [7:0]        reg_byte,
  input  logic [15:0]       ptr,
  output logic [ADDR_W-1:0] addr
);
  import xbus_pkg::*;

  always_comb begin
    addr = '0;
    unique case (kind)
      KIND_CODE_TBL: addr = {pc[ADDR_W-1:16], ptr};  // missing bits from pc
      KIND_REG8:     addr[7:0]  = reg_byte;          // zero above bit 7
      KIND_PTR16:    addr[15:0] = ptr;               // zero above bit 15
      default:       addr = pc;                      // instruction fetch
    endcase
  end

endmodule

// File: rtl/xbus_phase_ctrl.sv
module xbus_phase_ctrl #(
  parameter int STROBE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output xbus_pkg::phase_e phase,
  output logic             last_strb
);
  import xbus_pkg::*;

  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last_strb = (phase_q == PH_STRB) && (cnt_q == CNT_LAST);

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start) phase_d = PH_ALE;
      PH_ALE:  phase_d = PH_HOLD;
      PH_HOLD: begin
        phase_d = PH_STRB;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      PH_STRB: begin
        if (cnt_q == CNT_LAST) begin
          phase_d = PH_DONE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else begin
      phase_q <= phase_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive #(
  parameter int ADDR_W = 23
) (
  input  xbus_pkg::phase_e    phase,
  input  xbus_pkg::acc_attr_t attr,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [7:0]          wdata,
  output logic                ale,
  output logic                psen_n,
  output logic                rd_n,
  output logic                wr_n,
  output logic [7:0]          p0_out,
  output logic                p0_oe,
  output logic [7:0]          p2_out
);
  import xbus_pkg::*;

  localparam int HI_W = ADDR_W - 16;

  logic [7:0] hi_top;
  logic       strb;
  logic       drive_wd;

  // top address bits, zero padded to the port width
  generate
    if (HI_W == 8) begin : g_hi_full
      assign hi_top = addr[ADDR_W-1:16];
    end else begin : g_hi_pad
      assign hi_top = {{(8-HI_W){1'b0}}, addr[ADDR_W-1:16]};
    end
  endgenerate

  assign strb     = (phase == PH_STRB);
  assign drive_wd = attr.wr && !attr.is_code;

  always_comb begin
    ale    = (phase == PH_ALE);
    psen_n = !(strb && attr.is_code);
    rd_n   = !(strb && !attr.is_code && !attr.wr);
    wr_n   = !(strb && drive_wd);
  end

  // high port: top bits during ALE in extended mode, else bits 15:8
  always_comb begin
    unique case (phase)
      PH_IDLE: p2_out = '0;
      PH_ALE:  p2_out = attr.ext ? hi_top : addr[15:8];
      default: p2_out = addr[15:8];
    endcase
  end

  // low port: address during latch and hold, write data under the strobe
  always_comb begin
    p0_out = '0;
    p0_oe  = 1'b0;
    unique case (phase)
      PH_ALE, PH_HOLD: begin
        p0_out = addr[7:0];
        p0_oe  = 1'b1;
      end
      PH_STRB: begin
        if (drive_wd) begin
          p0_out = wdata;
          p0_oe  = 1'b1;
        end
      end
      default: begin
        p0_out = '0;
        p0_oe  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ADDR_W     = 23,
  parameter int STROBE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] pc,
  input  logic [7:0]        reg_byte,
  input  logic [15:0]       ptr,
  input  logic [7:0]        wdata,
  input  logic [7:0]        p0_in,
  output logic [7:0]        p0_out,
  output logic              p0_oe,
  output logic [7:0]        p2_out,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rd_data
);
  import xbus_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e            phase;
  logic              last_strb;
  logic              start;
  logic [ADDR_W-1:0] addr_new, addr_q;
  acc_attr_t         attr_new, attr_q;
  logic [7:0]        wdata_q;
  logic [7:0]        rd_data_q;
  logic              rd_cap_en;

  assign start = req_valid && (phase == PH_IDLE);

  xbus_addr_form #(.ADDR_W(ADDR_W)) u_addr (
    .kind     (req_kind),
    .pc       (pc),
    .reg_byte (reg_byte),
    .ptr      (ptr),
    .addr     (addr_new)
  );

  always_comb begin
    attr_new.ext     = ext_mode;
    attr_new.is_code = (req_kind == KIND_CODE_TBL) || (req_kind == KIND_FETCH);
    attr_new.wr      = req_write && !attr_new.is_code;
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      addr_q  <= '0;
      attr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= addr_new;
      attr_q  <= attr_new;
      wdata_q <= wdata;
    end
  end

  xbus_phase_ctrl #(.STROBE_CYC(STROBE_CYC)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .phase     (phase),
    .last_strb (last_strb)
  );

  xbus_pin_drive #(.ADDR_W(ADDR_W)) u_pins (
    .phase  (phase),
    .attr   (attr_q),
    .addr   (addr_q),
    .wdata  (wdata_q),
    .ale    (ale),
    .psen_n (psen_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .p0_out (p0_out),
    .p0_oe  (p0_oe),
    .p2_out (p2_out)
  );

  // read data taken at the edge that raises the strobe
  assign rd_cap_en = last_strb && !attr_q.wr;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rd_data_q <= '0;
    end else if (rd_cap_en) begin
      rd_data_q <= p0_in;
    end
  end

  assign rd_data = rd_data_q;
  assign busy    = (phase != PH_IDLE);
  assign done    = (phase == PH_DONE);

endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       p0_oe,
  input logic [7:0] p2_out,
  input logic       busy,
  input logic       done
);
  logic strb_any;
  assign strb_any = !(psen_n && rd_n && wr_n);

  // R6: one strobe at a time
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  // R7: latch enable never overlaps a strobe
  p_ale_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !strb_any);

  // R3: high port steady while a strobe stays low
  p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_any && $past(strb_any)) |-> $stable(p2_out));

  // R8: port driven under write strobe, released under read strobes
  p_wr_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> p0_oe);

  p_rd_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !psen_n) |-> !p0_oe);

  // R11: done lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5: done inside busy, never with ale or strobe
  p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !ale && !strb_any));

  // R5: a strobe only while busy
  p_strb_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_any || ale) |-> busy);

endmodule

bind xbus_seq xbus_seq_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ale    (ale),
  .psen_n (psen_n),
  .rd_n   (rd_n),
  .wr_n   (wr_n),
  .p0_oe  (p0_oe),
  .p2_out (p2_out),
  .busy   (busy),
  .done   (done)
);

// File: tb/sim_xbus_seq.sv
module sim_xbus_seq;

  localparam int ADDR_W     = 23;
  localparam int STROBE_CYC = 2;

  logic              clk;
  logic              rst_n;
  logic              ext_mode;
  logic              req_valid;
  logic [1:0]        req_kind;
  logic              req_write;
  logic [ADDR_W-1:0] pc;
  logic [7:0]        reg_byte;
  logic [15:0]       ptr;
  logic [7:0]        wdata;
  logic [7:0]        p0_in;
  logic [7:0]        p0_out;
  logic              p0_oe;
  logic [7:0]        p2_out;
  logic              ale;
  logic              psen_n;
  logic              rd_n;
  logic              wr_n;
  logic              busy;
  logic              done;
  logic [7:0]        rd_data;

  int nchk  = 0;
  int nfail = 0;
  int cyc   = 0;
  logic [7:0] last_rd = 8'h00;

  xbus_seq #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .req_valid(req_valid),
    .req_kind(req_kind), .req_write(req_write), .pc(pc), .reg_byte(reg_byte),
    .ptr(ptr), .wdata(wdata), .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .busy(busy), .done(done), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        mode;
    logic [1:0]  kind;
    logic        wr;
    logic [22:0] pc;
    logic [7:0]  rb;
    logic [15:0] ptr;
    logic [7:0]  wd;
    logic [7:0]  rv;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 1'b0, 23'h000000, 8'h00, 16'h1234, 8'h00, 8'hA5},
    '{1'b0, 2'd1, 1'b1, 23'h000000, 8'h7E, 16'h0000, 8'h3C, 8'h00},
    '{1'b0, 2'd0, 1'b0, 23'h5A0000, 8'h00, 16'hBEEF, 8'h00, 8'h96},
    '{1'b1, 2'd2, 1'b1, 23'h7F0000, 8'h00, 16'hC0DE, 8'h81, 8'h00},
    '{1'b1, 2'd1, 1'b0, 23'h7FFFFF, 8'hFF, 16'hFFFF, 8'h00, 8'h5F},
    '{1'b1, 2'd0, 1'b0, 23'h7F1234, 8'h00, 16'h0102, 8'h00, 8'hE7},
    '{1'b1, 2'd0, 1'b1, 23'h2A0000, 8'h00, 16'hABCD, 8'h55, 8'h11},
    '{1'b1, 2'd3, 1'b0, 23'h345678, 8'h99, 16'h4321, 8'h00, 8'h3D},
    '{1'b0, 2'd3, 1'b0, 23'h7FFF00, 8'h00, 16'h0000, 8'h00, 8'hC4}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R4 address formation, computed independently
  function automatic logic [22:0] exp_addr(input vec_t v);
    case (v.kind)
      2'd0:    return {v.pc[22:16], v.ptr};
      2'd1:    return {15'b0, v.rb};
      2'd2:    return {7'b0, v.ptr};
      default: return v.pc;
    endcase
  endfunction

  task automatic chk_strobes(input vec_t v, input bit active, input string tag);
    bit is_code;
    is_code = (v.kind == 2'd0) || (v.kind == 2'd3);
    chk(psen_n == !(active && is_code), {tag, " R6 psen_n"}, psen_n, !(active && is_code));
    chk(rd_n == !(active && !is_code && !v.wr), {tag, " R6 rd_n"}, rd_n,
        !(active && !is_code && !v.wr));
    chk(wr_n == !(active && !is_code && v.wr), {tag, " R6 wr_n"}, wr_n,
        !(active && !is_code && v.wr));
  endtask

  // one full access; disturb=1 scrambles the inputs while busy (R10)
  task automatic run_access(input vec_t v, input bit disturb);
    logic [22:0] a;
    logic [7:0]  hi_ale;
    bit          is_code;
    bit          wr_eff;
    a       = exp_addr(v);
    hi_ale  = v.mode ? {1'b0, a[22:16]} : a[15:8];
    is_code = (v.kind == 2'd0) || (v.kind == 2'd3);
    wr_eff  = v.wr && !is_code;

    @(negedge clk);
    ext_mode  = v.mode;
    req_kind  = v.kind;
    req_write = v.wr;
    pc        = v.pc;
    reg_byte  = v.rb;
    ptr       = v.ptr;
    wdata     = v.wd;
    p0_in     = ~v.rv;
    req_valid = 1'b1;

    // latch phase
    @(negedge clk);
    if (disturb) begin
      ext_mode  = ~v.mode;
      req_kind  = v.kind + 2'd1;
      req_write = ~v.wr;
      pc        = ~v.pc;
      reg_byte  = ~v.rb;
      ptr       = ~v.ptr;
      wdata     = ~v.wd;
    end else begin
      req_valid = 1'b0;
    end
    chk(ale == 1'b1, "R5 ale high in latch phase", ale, 1);
    chk(busy == 1'b1, "R5 busy in latch phase", busy, 1);
    chk(p2_out == hi_ale, v.mode ? "R3 high port top bits at ALE" :
        "R2 high port mid byte at ALE", p2_out, hi_ale);
    chk(p0_out == a[7:0] && p0_oe, "R4 low address byte at ALE", p0_out, a[7:0]);
    chk_strobes(v, 1'b0, "latch");

    // hold phase
    @(negedge clk);
    chk(ale == 1'b0, "R5 ale low in hold", ale, 0);
    chk(p2_out == a[15:8], "R3 high port mid byte after ALE", p2_out, a[15:8]);
    chk(p0_out == a[7:0] && p0_oe, "R2 low address held", p0_out, a[7:0]);
    chk_strobes(v, 1'b0, "hold");

    // strobe phase
    for (int i = 0; i < STROBE_CYC; i++) begin
      @(negedge clk);
      if (i == STROBE_CYC - 1) p0_in = v.rv;
      chk_strobes(v, 1'b1, "strobe R10");
      chk(ale == 1'b0, "R7 ale low under strobe", ale, 0);
      chk(p2_out == a[15:8], "R3 high byte under strobe", p2_out, a[15:8]);
      chk(p0_oe == wr_eff, "R8 low port enable under strobe", p0_oe, wr_eff);
      if (wr_eff) chk(p0_out == v.wd, "R8 write data under strobe", p0_out, v.wd);
    end

    // completion
    @(negedge clk);
    req_valid = 1'b0;
    p0_in     = 8'h00;
    chk(done == 1'b1 && busy == 1'b1, "R11 done in completion cycle", done, 1);
    chk_strobes(v, 1'b0, "R5 completion");
    if (!wr_eff) last_rd = v.rv;
    chk(rd_data == last_rd, "R9 read data", rd_data, last_rd);

    // back to idle, nothing queued
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10 R11 idle after access", {busy, done}, 0);
    chk(ale == 1'b0, "R10 no new latch phase", ale, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog act=%0d exp<=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_mode = 1'b0; req_valid = 1'b0; req_kind = 2'd0;
    req_write = 1'b0; pc = '0; reg_byte = '0; ptr = '0; wdata = '0; p0_in = '0;
    repeat (3) @(negedge clk);
    // R1 state in reset
    chk(ale == 0 && psen_n && rd_n && wr_n, "R1 strobes idle in reset",
        {ale, psen_n, rd_n, wr_n}, 4'b0111);
    chk(busy == 0 && done == 0 && p0_oe == 0 && p2_out == 0, "R1 idle in reset",
        {busy, done, p0_oe, p2_out}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && p2_out == 0 && rd_data == 0, "R1 idle after release",
        {busy, p2_out, rd_data}, 0);

    // table walk
    for (int k = 0; k < NV; k++) run_access(VECS[k], 1'b0);

    // R10: scrambled inputs while busy
    run_access(VECS[5], 1'b1);
    run_access(VECS[3], 1'b1);

    // R1: reset in the middle of a strobe
    @(negedge clk);
    ext_mode = 1'b1; req_kind = 2'd2; req_write = 1'b1; ptr = 16'h5566;
    wdata = 8'h77; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(wr_n == 1'b0, "R6 write strobe before reset", wr_n, 0);
    rst_n = 1'b0;
    #1;
    chk(wr_n && !busy && !p0_oe && p2_out == 0, "R1 async reset mid access",
        {wr_n, busy, p0_oe, p2_out}, 11'h400);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_rd = 8'h00;
    chk(rd_data == 8'h00, "R1 read data cleared by reset", rd_data, 0);
    run_access(VECS[4], 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule